// File: doc/BRIEF.md
# Peak-Windowed Cross-Correlation Lag Finder

This block estimates the delay between two channels of a sampled signal. Both channel records are already stored in buffers with their DC offset removed, and the index of the signal peak is known. On a start pulse the block correlates only a window of samples around that peak, for a bounded set of lags in both directions. It reports the lag whose correlation is largest, together with that correlation value.

The block reads both buffers through two independent address/data ports with combinational read data. It multiplies one sample pair per cycle on a single shared multiplier and accumulates the products at full precision. Converting the lag into a distance or an angle is left to downstream logic.

Top module: `xcorr_lag_finder`

## Requirements
- R1: After reset, `done` is 0, `lag` is 0 and `max_corr` is 0.
- R2: For peak index p, each lag sums exactly 2*HALF_WIN products over base indices n = p-HALF_WIN up to p+HALF_WIN-1.
- R3: For a lag k >= 0 the right channel is shifted: the sum is L[n]*R[n+k]. For k < 0 the left channel is shifted: the sum is L[n+|k|]*R[n]. Lags run from -MAX_LAG to +MAX_LAG, and the zero-lag sum is computed once.
- R4: A sample whose index is below 0 or at or above DEPTH contributes zero to the sum.
- R5: Samples are signed 16-bit Q1.15. `lag` is the lag with the largest sum, and `max_corr` is that sum as a signed ACC_W-bit integer of raw product units, with no overflow even when every product is full scale.
- R6: Lags are evaluated in the order 0, +1, -1, +2, -2 and so on, and only a strictly larger sum replaces the best one. On equal sums the smaller |lag| therefore wins, and between +k and -k the positive lag wins.
- R7: `done` is a single-cycle pulse raised (2*MAX_LAG+1)*2*HALF_WIN clock edges after the edge that samples `start`.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The run's peak, timing and results are unchanged.
- R9: `lag` and `max_corr` hold their values from one `done` to the next, including during a run.
- R10: A positive `lag` means the right channel lags the left, i.e. R[n] = L[n-lag] gives `lag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, ignored while busy |
| peak_idx | input | ADDR_W | Index of the detected peak |
| rd_addr_l | output | ADDR_W | Left buffer read address |
| rd_data_l | input | 16 | Left sample, Q1.15, combinational read |
| rd_addr_r | output | ADDR_W | Right buffer read address |
| rd_data_r | input | 16 | Right sample, Q1.15, combinational read |
| lag | output | LAG_W | Signed lag of the best correlation |
| max_corr | output | ACC_W | Signed best correlation sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a tie between +k and -k that is not also beaten by the zero-lag sum. Random data almost never produces it. The bench builds it directly: the left buffer holds a single impulse, and the right buffer holds two impulses one sample either side, so only lags +1 and -1 produce a nonzero sum. Peaks placed at the first and last record positions drive the window past both buffer ends. A full-scale constant fill makes all lags tie at the largest possible sum.

// File: rtl/xcorr_lag_finder.sv
module xcorr_lag_finder #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int DEPTH    = 1024,
  parameter int HALF_WIN = 500,
  parameter int MAX_LAG  = 20,
  parameter int LAG_W    = 6,
  parameter int ACC_W    = 42
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        peak_idx,
  output logic [ADDR_W-1:0]        rd_addr_l,
  input  logic signed [DATA_W-1:0] rd_data_l,
  output logic [ADDR_W-1:0]        rd_addr_r,
  input  logic signed [DATA_W-1:0] rd_data_r,
  output logic signed [LAG_W-1:0]  lag,
  output logic signed [ACC_W-1:0]  max_corr,
  output logic                     done
);
  localparam int NLAG = 2 * MAX_LAG + 1;
  localparam int NWIN = 2 * HALF_WIN;
  localparam int MW   = $clog2(NLAG) + 1;
  localparam int JW   = $clog2(NWIN) + 1;
  localparam int IW   = ((ADDR_W > JW) ? ADDR_W : JW) + 3;
  localparam int PW   = 2 * DATA_W;

  logic              running;
  logic [ADDR_W-1:0] peak_q;
  logic [MW-1:0]     m;
  logic [JW-1:0]     j;
  logic signed [ACC_W-1:0] acc, best;
  logic signed [LAG_W-1:0] best_lag;

  logic [MW-1:0] kmag;
  logic          pos;
  logic signed [LAG_W-1:0] cur_lag;
  logic [IW-1:0] base, li, ri;
  logic          ok_l, ok_r, last_j, last_m, take;
  logic signed [DATA_W-1:0] lv, rv;
  logic signed [PW-1:0]     prod;
  logic signed [ACC_W-1:0]  sum_n;

  assign kmag    = MW'((m + MW'(1)) >> 1);
  assign pos     = m[0];
  assign cur_lag = pos ? LAG_W'(kmag) : -LAG_W'(kmag);

  assign base = {{(IW-ADDR_W){1'b0}}, peak_q} + {{(IW-JW){1'b0}}, j} - IW'(HALF_WIN);
  assign li   = base + (pos ? '0 : {{(IW-MW){1'b0}}, kmag});
  assign ri   = base + (pos ? {{(IW-MW){1'b0}}, kmag} : '0);
  assign ok_l = !li[IW-1] && (li < IW'(DEPTH));
  assign ok_r = !ri[IW-1] && (ri < IW'(DEPTH));

  assign rd_addr_l = li[ADDR_W-1:0];
  assign rd_addr_r = ri[ADDR_W-1:0];
  assign lv    = ok_l ? rd_data_l : '0;
  assign rv    = ok_r ? rd_data_r : '0;
  assign prod  = lv * rv;
  assign sum_n = acc + {{(ACC_W-PW){prod[PW-1]}}, prod};

  assign last_j = (j == JW'(NWIN - 1));
  assign last_m = (m == MW'(NLAG - 1));
  assign take   = (m == '0) || (sum_n > best);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      peak_q   <= '0;
      m        <= '0;
      j        <= '0;
      acc      <= '0;
      best     <= '0;
      best_lag <= '0;
      lag      <= '0;
      max_corr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          peak_q  <= peak_idx;
          m       <= '0;
          j       <= '0;
          acc     <= '0;
        end
      end else if (!last_j) begin
        j   <= j + JW'(1);
        acc <= sum_n;
      end else begin
        j   <= '0;
        acc <= '0;
        m   <= m + MW'(1);
        if (take) begin
          best     <= sum_n;
          best_lag <= cur_lag;
        end
        if (last_m) begin
          running  <= 1'b0;
          done     <= 1'b1;
          max_corr <= take ? sum_n : best;
          lag      <= take ? cur_lag : best_lag;
        end
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(running));

  a_r3_lag_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lag <= LAG_W'(MAX_LAG)) && (lag >= -LAG_W'(MAX_LAG)));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> $stable(peak_q));

  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lag) && $stable(max_corr)));

  a_r2_window_count: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !last_j) |=> (j == $past(j) + JW'(1)));
endmodule

// File: tb/xcorr_lag_finder_tb.sv
module xcorr_lag_finder_tb;
  localparam int AW = 6, DP = 64, HW = 16, ML = 4, LW = 6, AC = 42;
  localparam int NCYC = (2*ML+1) * 2*HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] peak_idx = '0;
  logic [AW-1:0] rd_addr_l, rd_addr_r;
  logic signed [15:0] rd_data_l, rd_data_r;
  logic signed [LW-1:0] lag;
  logic signed [AC-1:0] max_corr;
  logic done;

  logic signed [15:0] mem_l [DP];
  logic signed [15:0] mem_r [DP];

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign rd_data_l = mem_l[rd_addr_l];
  assign rd_data_r = mem_r[rd_addr_r];

  xcorr_lag_finder #(.DATA_W(16), .ADDR_W(AW), .DEPTH(DP), .HALF_WIN(HW),
                     .MAX_LAG(ML), .LAG_W(LW), .ACC_W(AC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .peak_idx(peak_idx),
    .rd_addr_l(rd_addr_l), .rd_data_l(rd_data_l),
    .rd_addr_r(rd_addr_r), .rd_data_r(rd_data_r),
    .lag(lag), .max_corr(max_corr), .done(done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint samp_l(input int i);
    return (i < 0 || i >= DP) ? 0 : longint'(mem_l[i]);
  endfunction
  function automatic longint samp_r(input int i);
    return (i < 0 || i >= DP) ? 0 : longint'(mem_r[i]);
  endfunction

  task automatic ref_model(input int p, output int e_lag, output longint e_val);
    e_lag = 0; e_val = 0;
    for (int m = 0; m < 2*ML+1; m++) begin
      int k = (m + 1) / 2;
      bit ps = (m % 2) == 1;
      longint s = 0;
      for (int n = p - HW; n < p + HW; n++)
        s += ps ? samp_l(n) * samp_r(n + k) : samp_l(n + k) * samp_r(n);
      if (m == 0 || s > e_val) begin
        e_val = s;
        e_lag = ps ? k : -k;
      end
    end
  endtask

  task automatic run_case(input int p, input string req, input bit busy_start);
    int e_lag, cyc;
    longint e_val;
    ref_model(p, e_lag, e_val);
    @(negedge clk); peak_idx = AW'(p); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4*NCYC) begin
      @(negedge clk);
      cyc++;
      if (busy_start && cyc == 5) begin start = 1'b1; peak_idx = AW'(p + 7); end
      else start = 1'b0;
    end
    check(cyc == NCYC, "R7 done latency", cyc, NCYC);
    check(int'(lag) == e_lag, req, lag, e_lag);
    check(longint'(max_corr) == e_val, req, max_corr, e_val);
    repeat (3) @(negedge clk);
    check(!done, "R7 single pulse", done, 0);
    check(int'(lag) == e_lag && longint'(max_corr) == e_val, "R9 hold after done", max_corr, e_val);
  endtask

  task automatic fill_delayed(input int d, input int noise);
    for (int i = 0; i < DP; i++) mem_l[i] = 16'($urandom_range(0, 65535));
    for (int i = 0; i < DP; i++)
      mem_r[i] = 16'(samp_l(i - d) + longint'($signed(16'($urandom_range(0, 2*noise)))) - noise);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DP; i++) begin mem_l[i] = '0; mem_r[i] = '0; end
    repeat (3) @(negedge clk);
    check(!done && lag == 0 && max_corr == 0, "R1 reset state", max_corr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done, "R1 idle after reset", done, 0);

    // R10 / R3: right channel is a delayed copy, positive and negative delays
    for (int d = -ML; d <= ML; d += 2) begin
      fill_delayed(d, 50);
      run_case(32, "R10 delayed copy", 1'b0);
      check(int'(lag) == d, "R10 lag sign", lag, d);
    end

    // R2/R5: pure random data, random peaks
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < DP; i++) begin
        mem_l[i] = 16'($urandom_range(0, 65535));
        mem_r[i] = 16'($urandom_range(0, 65535));
      end
      run_case(int'($urandom_range(0, DP-1)), "R5 random argmax", 1'b0);
    end

    // R4: windows crossing both record ends
    fill_delayed(2, 20);
    run_case(0, "R4 window below zero", 1'b0);
    fill_delayed(-3, 20);
    run_case(DP-1, "R4 window past end", 1'b0);

    // R5/R6: full-scale constant fill, all lags tie at maximum
    for (int i = 0; i < DP; i++) begin mem_l[i] = 16'h8000; mem_r[i] = 16'h8000; end
    run_case(32, "R5 full scale no overflow", 1'b0);
    check(int'(lag) == 0, "R6 tie picks zero lag", lag, 0);
    check(longint'(max_corr) == longint'(2*HW) * (longint'(1) << 30), "R5 full scale value",
          max_corr, longint'(2*HW) * (longint'(1) << 30));

    // R6: +1 and -1 tie, zero lag loses
    for (int i = 0; i < DP; i++) begin mem_l[i] = '0; mem_r[i] = '0; end
    mem_l[30] = 16'sd1000; mem_r[31] = 16'sd1000; mem_r[29] = 16'sd1000;
    run_case(30, "R6 tie order", 1'b0);
    check(int'(lag) == 1, "R6 positive wins tie", lag, 1);

    // R8: start during a run is ignored
    fill_delayed(-1, 30);
    run_case(20, "R8 busy start ignored", 1'b1);
    @(negedge clk);
    check(!done, "R8 no second run", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule